// File: doc/BRIEF.md
# Paging Control Register Unit

This unit keeps the paging-related control state of a processor core: the system control word, the page-fault address register, the translation root register, the extension-enable word and a long-mode-enable bit held in an extended-feature register. An execution unit reads and writes these registers through a synchronous register port. Each request carries the privilege level of the code that issued it. The unit also captures the faulting linear address when a page fault is reported.

From the stored state the unit decodes the active translation mode and passes it, together with the individual control flags and the translation root, to the table-walk logic. Only privilege level 0 may touch the registers. An access from any other level is refused and raises a general-protection pulse. An access to the reserved slot, or to a register number that is not implemented, raises a separate illegal-access pulse.

Top module: `pgctl_top`

## Requirements
- R1: While reset is asserted, and after it is released, every register reads as zero. All exported flags are 0, `mode_o` is 00, and the `rd_valid_o`, `gp_fault_o` and `illegal_o` outputs are all 0.
- R2: `mode_o` encodes the mode as follows: 00 when PG=0; 01 when PG=1 and PAE=0; 10 when PG=1, PAE=1 and LME=0; 11 when PG=1, PAE=1 and LME=1. It reflects a write from the cycle after that write.
- R3: A request with `req_cpl_i` not equal to 0 produces a one-cycle `gp_fault_o` pulse in the next cycle. It changes no register, and it returns no read data (`rd_valid_o`=0, `rd_data_o`=0).
- R4: The register numbers are 0 = control word, 2 = fault address, 3 = root, 4 = extension word and 5 = extended feature. A privilege-0 request to number 1, 6 or 7 produces a one-cycle `illegal_o` pulse in the next cycle and changes no register.
- R5: The root register keeps bits 31:12 as the table base and keeps bits 4 (PCD) and 3 (PWT). Every other bit reads as zero. `root_base_o` carries bits 31:12, and `root_pcd_o` and `root_pwt_o` carry the two flags.
- R6: The exported flags come from fixed bit positions. In the control word, PG is bit 31, WP is bit 16, EM is bit 2 and PE is bit 0. In the extension word, PAE is bit 5 and PSE is bit 4. In the extended-feature register, LME is bit 8.
- R7: A cycle with `pf_valid_i` high loads `pf_addr_i` into the fault-address register. If a write to that register happens in the same cycle, the fault capture wins.
- R8: A legal privilege-0 read returns the register value on `rd_data_o`, with `rd_valid_o` high, in the next cycle. The control word, extension word and fault address keep all 32 bits. The extended-feature register keeps only bit 8. `rd_data_o` is 0 whenever `rd_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Register request strobe |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 3 | Register number |
| req_wdata_i | input | 32 | Write data |
| req_cpl_i | input | 2 | Privilege level of the requester |
| rd_data_o | output | 32 | Read data |
| rd_valid_o | output | 1 | Read data valid |
| gp_fault_o | output | 1 | Privilege violation pulse |
| illegal_o | output | 1 | Unimplemented or reserved register pulse |
| pf_valid_i | input | 1 | Page-fault report strobe |
| pf_addr_i | input | 32 | Faulting linear address |
| mode_o | output | 2 | Decoded translation mode |
| pg_o | output | 1 | Paging enable |
| pe_o | output | 1 | Protection enable |
| wp_o | output | 1 | Supervisor write protect |
| em_o | output | 1 | Emulation flag |
| pae_o | output | 1 | Physical address extension |
| pse_o | output | 1 | Large page enable |
| lme_o | output | 1 | Long mode enable |
| root_base_o | output | 20 | Root table base, bits 31:12 |
| root_pcd_o | output | 1 | Root access cache disable |
| root_pwt_o | output | 1 | Root access write-through |

## Verification
The mode decoder is stepped through all four PG/PAE/LME combinations, and PG is then cleared while PAE and LME stay set. This shows whether PG alone gates the mode. Writes are tried at every nonzero privilege level and to register numbers 1, 6 and 7; the following reads show whether a refused access left any state behind. The root register is written with all ones and with a pattern that has the cache flags clear, which separates correct bit masking from plain pass-through. A fault capture is issued alone, in the same cycle as a write to the fault register, and in the same cycle as a refused request, to exercise the capture priority.

// File: rtl/pgctl_pkg.sv
package pgctl_pkg;
  localparam int XLEN       = 32;
  localparam int RADDR_W    = 3;
  localparam int CPL_W      = 2;
  localparam int PAGE_SHIFT = 12;

  localparam logic [RADDR_W-1:0] REG_CTRL = 3'd0;
  localparam logic [RADDR_W-1:0] REG_RSVD = 3'd1;
  localparam logic [RADDR_W-1:0] REG_FADR = 3'd2;
  localparam logic [RADDR_W-1:0] REG_ROOT = 3'd3;
  localparam logic [RADDR_W-1:0] REG_EXTN = 3'd4;
  localparam logic [RADDR_W-1:0] REG_FEAT = 3'd5;

  localparam int BIT_PG  = 31;
  localparam int BIT_WP  = 16;
  localparam int BIT_EM  = 2;
  localparam int BIT_PE  = 0;
  localparam int BIT_PAE = 5;
  localparam int BIT_PSE = 4;
  localparam int BIT_PCD = 4;
  localparam int BIT_PWT = 3;
  localparam int BIT_LME = 8;

  typedef enum logic [1:0] {
    MODE_NONE = 2'b00,
    MODE_32   = 2'b01,
    MODE_PAE  = 2'b10,
    MODE_LONG = 2'b11
  } xlat_mode_e;
endpackage

// File: rtl/pgctl_access.sv
module pgctl_access
  import pgctl_pkg::*;
#(
  parameter int AW = RADDR_W,
  parameter int CW = CPL_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          write_i,
  input  logic [AW-1:0] addr_i,
  input  logic [CW-1:0] cpl_i,
  output logic          wr_o,
  output logic          rd_o,
  output logic          gp_o,
  output logic          ill_o
);
  logic priv_ok, known, ok;

  always_comb begin
    unique case (addr_i)
      REG_CTRL, REG_FADR, REG_ROOT, REG_EXTN, REG_FEAT: known = 1'b1;
      default:                                          known = 1'b0;
    endcase
  end

  assign priv_ok = (cpl_i == '0);
  assign ok      = valid_i && priv_ok && known;
  assign wr_o    = ok && write_i;
  assign rd_o    = ok && !write_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gp_o  <= 1'b0;
      ill_o <= 1'b0;
    end else begin
      gp_o  <= valid_i && !priv_ok;
      ill_o <= valid_i && priv_ok && !known;
    end
  end

  p_gp_excl_ill_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(gp_o && ill_o));
  p_gp_after_bad_cpl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cpl_i != '0) |=> gp_o);
endmodule

// File: rtl/pgctl_regfile.sv
module pgctl_regfile
  import pgctl_pkg::*;
#(
  parameter int W  = XLEN,
  parameter int AW = RADDR_W,
  parameter int PS = PAGE_SHIFT
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          pf_valid_i,
  input  logic [W-1:0]  pf_addr_i,
  output logic [W-1:0]  ctrl_o,
  output logic [W-1:0]  extn_o,
  output logic [W-1:0]  root_o,
  output logic          lme_o,
  output logic [W-1:0]  rd_data_o,
  output logic          rd_valid_o
);
  localparam logic [W-1:0] ROOT_MASK =
    ({W{1'b1}} << PS) | (W'(1) << BIT_PCD) | (W'(1) << BIT_PWT);

  logic [W-1:0] ctrl_q, fadr_q, root_q, extn_q;
  logic         lme_q;
  logic [W-1:0] rd_mux;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      fadr_q <= '0;
      root_q <= '0;
      extn_q <= '0;
      lme_q  <= 1'b0;
    end else begin
      if (wr_i) begin
        unique case (addr_i)
          REG_CTRL: ctrl_q <= wdata_i;
          REG_ROOT: root_q <= wdata_i & ROOT_MASK;
          REG_EXTN: extn_q <= wdata_i;
          REG_FEAT: lme_q  <= wdata_i[BIT_LME];
          default: ;
        endcase
      end
      // fault capture takes priority over a software write
      if (pf_valid_i)                       fadr_q <= pf_addr_i;
      else if (wr_i && addr_i == REG_FADR)  fadr_q <= wdata_i;
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (addr_i)
      REG_CTRL: rd_mux = ctrl_q;
      REG_FADR: rd_mux = fadr_q;
      REG_ROOT: rd_mux = root_q;
      REG_EXTN: rd_mux = extn_q;
      REG_FEAT: rd_mux[BIT_LME] = lme_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_o  <= '0;
      rd_valid_o <= 1'b0;
    end else begin
      rd_valid_o <= rd_i;
      rd_data_o  <= rd_i ? rd_mux : '0;
    end
  end

  assign ctrl_o = ctrl_q;
  assign extn_o = extn_q;
  assign root_o = root_q;
  assign lme_o  = lme_q;

  p_pf_capture_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pf_valid_i |=> fadr_q == $past(pf_addr_i));
  p_rd_zero_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_valid_o |-> rd_data_o == '0);
  p_root_low_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == REG_ROOT) |=> (rd_data_o[PS-1:BIT_PCD+1] == '0 && rd_data_o[BIT_PWT-1:0] == '0));
endmodule

// File: rtl/pgctl_mode_dec.sv
module pgctl_mode_dec
  import pgctl_pkg::*;
(
  input  logic       pg_i,
  input  logic       pae_i,
  input  logic       lme_i,
  output xlat_mode_e mode_o
);
  always_comb begin
    if (!pg_i)       mode_o = MODE_NONE;
    else if (!pae_i) mode_o = MODE_32;
    else if (!lme_i) mode_o = MODE_PAE;
    else             mode_o = MODE_LONG;
  end
endmodule

// File: rtl/pgctl_top.sv
module pgctl_top
  import pgctl_pkg::*;
(
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_valid_i,
  input  logic                       req_write_i,
  input  logic [RADDR_W-1:0]         req_addr_i,
  input  logic [XLEN-1:0]            req_wdata_i,
  input  logic [CPL_W-1:0]           req_cpl_i,
  output logic [XLEN-1:0]            rd_data_o,
  output logic                       rd_valid_o,
  output logic                       gp_fault_o,
  output logic                       illegal_o,
  input  logic                       pf_valid_i,
  input  logic [XLEN-1:0]            pf_addr_i,
  output logic [1:0]                 mode_o,
  output logic                       pg_o,
  output logic                       pe_o,
  output logic                       wp_o,
  output logic                       em_o,
  output logic                       pae_o,
  output logic                       pse_o,
  output logic                       lme_o,
  output logic [XLEN-PAGE_SHIFT-1:0] root_base_o,
  output logic                       root_pcd_o,
  output logic                       root_pwt_o
);
  logic            wr, rd;
  logic [XLEN-1:0] ctrl, extn, root;
  xlat_mode_e      mode;

  pgctl_access u_access (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (req_valid_i),
    .write_i (req_write_i),
    .addr_i  (req_addr_i),
    .cpl_i   (req_cpl_i),
    .wr_o    (wr),
    .rd_o    (rd),
    .gp_o    (gp_fault_o),
    .ill_o   (illegal_o)
  );

  pgctl_regfile u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr),
    .rd_i       (rd),
    .addr_i     (req_addr_i),
    .wdata_i    (req_wdata_i),
    .pf_valid_i (pf_valid_i),
    .pf_addr_i  (pf_addr_i),
    .ctrl_o     (ctrl),
    .extn_o     (extn),
    .root_o     (root),
    .lme_o      (lme_o),
    .rd_data_o  (rd_data_o),
    .rd_valid_o (rd_valid_o)
  );

  assign pg_o        = ctrl[BIT_PG];
  assign wp_o        = ctrl[BIT_WP];
  assign em_o        = ctrl[BIT_EM];
  assign pe_o        = ctrl[BIT_PE];
  assign pae_o       = extn[BIT_PAE];
  assign pse_o       = extn[BIT_PSE];
  assign root_base_o = root[XLEN-1:PAGE_SHIFT];
  assign root_pcd_o  = root[BIT_PCD];
  assign root_pwt_o  = root[BIT_PWT];

  pgctl_mode_dec u_mode (
    .pg_i   (pg_o),
    .pae_i  (pae_o),
    .lme_i  (lme_o),
    .mode_o (mode)
  );
  assign mode_o = mode;

  p_no_change_on_gp_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_cpl_i != '0) |=> $stable({ctrl, extn, root, lme_o}));
  p_no_change_on_ill_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_cpl_i == '0 && (req_addr_i == REG_RSVD || req_addr_i > REG_FEAT))
      |=> $stable({ctrl, extn, root, lme_o}));
  p_resp_onehot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rd_valid_o, gp_fault_o, illegal_o}));
  p_mode_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pg_o |-> mode_o == 2'b00);
  p_mode_long_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pg_o && pae_o && lme_o) |-> mode_o == 2'b11);
endmodule

// File: tb/pgctl_top_test.sv
`timescale 1ns/1ps
module pgctl_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [2:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [1:0]  req_cpl = '0;
  logic        pf_valid = 1'b0;
  logic [31:0] pf_addr = '0;

  logic [31:0] rd_data;
  logic        rd_valid, gp_fault, illegal;
  logic [1:0]  mode;
  logic        pg, pe, wp, em, pae, pse, lme, pcd, pwt;
  logic [19:0] root_base;

  int n_tests = 0, n_fail = 0, cycles = 0;
  bit finished = 0;

  // behavioural reference state
  logic [31:0] m_ctrl = 0, m_fadr = 0, m_root = 0, m_extn = 0;
  logic        m_lme = 0;
  logic [31:0] m_rd = 0;
  logic        m_rv = 0, m_gp = 0, m_ill = 0;

  always #5 clk = ~clk;

  pgctl_top uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .req_cpl_i(req_cpl),
    .rd_data_o(rd_data), .rd_valid_o(rd_valid), .gp_fault_o(gp_fault), .illegal_o(illegal),
    .pf_valid_i(pf_valid), .pf_addr_i(pf_addr),
    .mode_o(mode), .pg_o(pg), .pe_o(pe), .wp_o(wp), .em_o(em),
    .pae_o(pae), .pse_o(pse), .lme_o(lme),
    .root_base_o(root_base), .root_pcd_o(pcd), .root_pwt_o(pwt)
  );

  function automatic logic [1:0] exp_mode();
    if (!m_ctrl[31])     return 2'b00;
    else if (!m_extn[5]) return 2'b01;
    else if (!m_lme)     return 2'b10;
    else                 return 2'b11;
  endfunction

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic compare(input string req);
    check(req, "rd_data", 64'(rd_data), 64'(m_rd));
    check(req, "resp", 64'({rd_valid, gp_fault, illegal}), 64'({m_rv, m_gp, m_ill}));
    check(req, "mode", 64'(mode), 64'(exp_mode()));
    check(req, "flags", 64'({pg, wp, em, pe, pae, pse, lme}),
          64'({m_ctrl[31], m_ctrl[16], m_ctrl[2], m_ctrl[0], m_extn[5], m_extn[4], m_lme}));
    check(req, "root", 64'({root_base, pcd, pwt}), 64'({m_root[31:12], m_root[4], m_root[3]}));
  endtask

  // one clock: drive at negedge, model at posedge, compare at next negedge
  task automatic step(input string req, input logic v, input logic w, input logic [2:0] a,
                      input logic [31:0] d, input logic [1:0] c,
                      input logic pv = 1'b0, input logic [31:0] pa = '0);
    logic known, ok;
    req_valid = v; req_write = w; req_addr = a; req_wdata = d; req_cpl = c;
    pf_valid = pv; pf_addr = pa;
    @(posedge clk);
    known = (a == 0) || (a == 2) || (a == 3) || (a == 4) || (a == 5);
    ok = v && (c == 0) && known;
    m_gp  = v && (c != 0);
    m_ill = v && (c == 0) && !known;
    m_rv  = ok && !w;
    m_rd  = 0;
    if (m_rv) begin
      case (a)
        0: m_rd = m_ctrl;
        2: m_rd = m_fadr;
        3: m_rd = m_root;
        4: m_rd = m_extn;
        5: m_rd = {23'd0, m_lme, 8'd0};
        default: m_rd = 0;
      endcase
    end
    if (ok && w) begin
      case (a)
        0: m_ctrl = d;
        2: m_fadr = d;
        3: m_root = {d[31:12], 7'd0, d[4], d[3], 3'd0};
        4: m_extn = d;
        5: m_lme  = d[8];
        default: ;
      endcase
    end
    if (pv) m_fadr = pa;
    @(negedge clk);
    compare(req);
  endtask

  task automatic idle(input string req);
    step(req, 1'b0, 1'b0, 3'd0, 32'd0, 2'd0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");
    step("R1", 1, 0, 3'd0, 0, 0);

    // R3: refused accesses at every nonzero level
    step("R3", 1, 1, 3'd0, 32'hFFFF_FFFF, 2'd3);
    step("R3", 1, 1, 3'd4, 32'hFFFF_FFFF, 2'd1);
    step("R3", 1, 0, 3'd0, 0, 2'd2);
    step("R3", 1, 0, 3'd0, 0, 2'd0);

    // R4: reserved and unimplemented numbers
    step("R4", 1, 1, 3'd1, 32'hFFFF_FFFF, 0);
    step("R4", 1, 1, 3'd6, 32'hFFFF_FFFF, 0);
    step("R4", 1, 0, 3'd7, 0, 0);
    step("R4", 1, 1, 3'd1, 32'h8000_0000, 2'd3);

    // R2 / R6: mode sequence
    step("R6", 1, 1, 3'd0, 32'h8001_0005, 0);
    idle("R2");
    step("R6", 1, 1, 3'd4, 32'h0000_0030, 0);
    step("R2", 1, 1, 3'd5, 32'hFFFF_FFFF, 0);
    step("R2", 1, 0, 3'd5, 0, 0);
    step("R2", 1, 1, 3'd0, 32'h0001_0001, 0);
    step("R2", 1, 1, 3'd4, 32'h0000_0010, 0);
    step("R2", 1, 1, 3'd0, 32'h8000_0000, 0);
    step("R2", 1, 1, 3'd5, 32'h0000_0000, 0);
    step("R2", 1, 1, 3'd4, 32'h0000_0020, 0);

    // R5: root register masking
    step("R5", 1, 1, 3'd3, 32'hFFFF_FFFF, 0);
    step("R5", 1, 0, 3'd3, 0, 0);
    step("R5", 1, 1, 3'd3, 32'h1234_5FE7, 0);
    step("R5", 1, 0, 3'd3, 0, 0);
    step("R5", 1, 1, 3'd3, 32'hABCD_E008, 0);

    // R7: fault capture and priority
    step("R7", 0, 0, 3'd0, 0, 0, 1'b1, 32'hDEAD_BEEF);
    step("R7", 1, 0, 3'd2, 0, 0);
    step("R7", 1, 1, 3'd2, 32'h1111_1111, 0, 1'b1, 32'h2222_2222);
    step("R7", 1, 0, 3'd2, 0, 0);
    step("R7", 1, 1, 3'd2, 32'h3333_3333, 0);
    step("R7", 1, 1, 3'd2, 32'h4444_4444, 2'd3, 1'b1, 32'h5555_5555);
    step("R7", 1, 0, 3'd2, 0, 0);

    // R8: full-width readback
    step("R8", 1, 1, 3'd0, 32'h7FFE_FFFA, 0);
    step("R8", 1, 0, 3'd0, 0, 0);
    step("R8", 1, 1, 3'd4, 32'hA5A5_5A5A, 0);
    step("R8", 1, 0, 3'd4, 0, 0);
    step("R8", 1, 1, 3'd5, 32'hFFFF_FFFF, 0);
    step("R8", 1, 0, 3'd5, 0, 0);
    idle("R8");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule